// File: doc/BRIEF.md
# Directional Tap Capture Classifier

This block sits behind a tap detector and works out which axis was struck and from which side. While armed it writes every valid three-axis sample into a circular history of `DEPTH` entries per axis, overwriting the oldest. A trigger pulse from the tap detector latches the per-axis tap flags and starts a post-trigger phase. After `POST` more valid samples have been stored, the history freezes. With the defaults this leaves 20 samples from before the trigger and 12 from after it.

The frozen history is then scanned, one entry per clock from the oldest. For every axis the scan tracks the largest and smallest sample and where each first occurs. When the scan ends, the block compares the flagged axes. The axis whose first extreme comes earliest wins, and a tie goes to the larger peak-to-peak swing. The direction comes from how the earlier peak compares with the later one. A one-cycle done strobe carries the axis code and the direction bit, and the history then re-arms for the next trigger.

The controller has four states. `ST_ARMED` records samples and waits for a trigger. `ST_POST` counts post-trigger samples. `ST_SCAN` walks the frozen history. `ST_DONE` presents the result for one cycle. The transitions are `ARM_TRIG` (ST_ARMED to ST_POST on a trigger), `POST_FULL` (ST_POST to ST_SCAN when the last post-trigger sample is stored), `SCAN_END` (ST_SCAN to ST_DONE after the newest entry has been read) and `REARM` (ST_DONE to ST_ARMED, unconditional).

Top module: `tap_dir_classifier`

## Requirements
- R1: During and right after reset, `res_done`, `res_axis` and `res_pos` are all 0. Every history entry reads as zero until it is first written.
- R2: While armed, the history holds the last 32 samples that had `smp_vld` high. Cycles with `smp_vld` low store nothing.
- R3: A trigger in the armed state starts the post-trigger phase. A sample presented in the trigger cycle counts as pre-trigger. Exactly 12 further valid samples are then stored, and samples presented after that are not stored.
- R4: `res_done` is high for exactly one cycle. It rises on the 32nd rising edge after the edge that stores the 12th post-trigger sample.
- R5: A trigger that arrives during the post-trigger, scan or done phase is ignored.
- R6: `tap_mask` bit 0 flags X, bit 1 flags Y and bit 2 flags Z. Only the value present in the accepted trigger cycle counts. Axis codes are 0 = none, 1 = X, 2 = Y, 3 = Z.
- R7: For each axis the scan finds the maximum and minimum signed values and the position of the first occurrence of each. Positions count 0..31 from the oldest stored sample. The axis's event time is the smaller of the two positions.
- R8: `res_pos` is 1 when the peak at the earlier position has a strictly larger magnitude than the peak at the later position, and 0 otherwise. It is also 0 when both positions are equal. Magnitudes are exact, so |-128| = 128.
- R9: Among flagged axes, the axis with the smallest event time wins.
- R10: When event times are equal, the larger max-minus-min swing wins. If the swings are also equal, the lower axis code wins.
- R11: With no axis flagged, done is still reported, with axis code 0 and `res_pos` 0.
- R12: `res_axis` and `res_pos` are 0 whenever `res_done` is 0.
- R13: After done, the block is armed again, and a trigger in the next cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Sample strobe for the three axis inputs |
| smp_x | input | DW | Signed X sample |
| smp_y | input | DW | Signed Y sample |
| smp_z | input | DW | Signed Z sample |
| trig | input | 1 | Tap trigger pulse |
| tap_mask | input | 3 | Per-axis tap flags, bit 0 = X, bit 1 = Y, bit 2 = Z |
| res_axis | output | 2 | Winning axis code, valid with `res_done` |
| res_pos | output | 1 | Direction, 1 = positive |
| res_done | output | 1 | One-cycle result strobe |

## Verification
The stimulus hides the tap pulses among zero samples, so that an off-by-one in the trigger boundary or in the oldest-entry pointer would move every peak position and change the winner. A design that stored samples during strobe gaps or after the freeze would report the wrong axis, and so would a design that took the mask from outside the trigger cycle. Repeated equal minima separate first-occurrence peak tracking from last-occurrence tracking, because the direction flips. A -128 against +127 pair catches a magnitude computed in too few bits. Equal event times with unequal or equal swings exercise both tie-break levels. Stray triggers during capture and scan, and a trigger in the first cycle after done, check that the block ignores or accepts them as R5 and R13 require.

// File: rtl/tap_cls_pkg.sv
package tap_cls_pkg;
    localparam int NAX = 3;

    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_POST  = 2'd1,
        ST_SCAN  = 2'd2,
        ST_DONE  = 2'd3
    } tap_state_e;
endpackage

// File: rtl/tap_capture_buf.sv
module tap_capture_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    parameter int NAX   = 3,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [NAX-1:0][DW-1:0]   din,
    input  logic [AW-1:0]            rd_off,
    output logic [NAX-1:0][DW-1:0]   dout
);
    logic [NAX-1:0][DEPTH-1:0][DW-1:0] mem;
    logic [AW-1:0]                     wp;
    logic [AW-1:0]                     ra;

    // wp always points at the oldest entry once the ring has wrapped
    assign ra = wp + rd_off;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            mem <= '0;
        end else if (we) begin
            wp <= wp + 1'b1;
            for (int a = 0; a < NAX; a++) mem[a][wp] <= din[a];
        end
    end

    always_comb begin
        for (int a = 0; a < NAX; a++) dout[a] = mem[a][ra];
    end

    p_wp_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> wp == $past(wp) + 1'b1);
endmodule

// File: rtl/tap_peak_scan.sv
module tap_peak_scan #(
    parameter int DW = 8,
    parameter int AW = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 en,
    input  logic signed [DW-1:0] smp,
    input  logic [AW-1:0]        pos,
    output logic [AW-1:0]        first_pos,
    output logic [DW:0]          swing,
    output logic                 pos_dir
);
    logic signed [DW-1:0] vmax, vmin;
    logic [AW-1:0]        pmax, pmin;
    logic                 seeded;
    logic signed [DW:0]   wmax, wmin;
    logic [DW:0]          mag_max, mag_min;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vmax <= '0; vmin <= '0; pmax <= '0; pmin <= '0; seeded <= 1'b0;
        end else if (clr) begin
            seeded <= 1'b0;
        end else if (en) begin
            // strict compare keeps the first occurrence of a repeated peak
            if (!seeded || smp > vmax) begin
                vmax <= smp; pmax <= pos;
            end
            if (!seeded || smp < vmin) begin
                vmin <= smp; pmin <= pos;
            end
            seeded <= 1'b1;
        end
    end

    always_comb begin
        wmax    = {vmax[DW-1], vmax};
        wmin    = {vmin[DW-1], vmin};
        mag_max = wmax[DW] ? $unsigned(-wmax) : $unsigned(wmax);
        mag_min = wmin[DW] ? $unsigned(-wmin) : $unsigned(wmin);
        swing   = $unsigned(wmax - wmin);
        if (pmax < pmin) begin
            first_pos = pmax;
            pos_dir   = mag_max > mag_min;
        end else if (pmin < pmax) begin
            first_pos = pmin;
            pos_dir   = mag_min > mag_max;
        end else begin
            first_pos = pmin;
            pos_dir   = 1'b0;
        end
    end

    p_peak_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seeded |-> vmax >= vmin);
endmodule

// File: rtl/tap_axis_arb.sv
module tap_axis_arb #(
    parameter int DW  = 8,
    parameter int AW  = 5,
    parameter int NAX = 3
) (
    input  logic [NAX-1:0]         mask,
    input  logic [NAX-1:0][AW-1:0] first_pos,
    input  logic [NAX-1:0][DW:0]   swing,
    input  logic [NAX-1:0]         pos_dir,
    output logic [1:0]             axis,
    output logic                   dir
);
    logic          found;
    logic [AW-1:0] bpos;
    logic [DW:0]   bsw;

    always_comb begin
        found = 1'b0;
        bpos  = '0;
        bsw   = '0;
        axis  = 2'd0;
        dir   = 1'b0;
        for (int a = 0; a < NAX; a++) begin
            if (mask[a] && (!found || first_pos[a] < bpos ||
                            (first_pos[a] == bpos && swing[a] > bsw))) begin
                found = 1'b1;
                bpos  = first_pos[a];
                bsw   = swing[a];
                axis  = 2'(a + 1);
                dir   = pos_dir[a];
            end
        end
    end
endmodule

// File: rtl/tap_dir_classifier.sv
module tap_dir_classifier
    import tap_cls_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    parameter int POST  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld,
    input  logic signed [DW-1:0] smp_x,
    input  logic signed [DW-1:0] smp_y,
    input  logic signed [DW-1:0] smp_z,
    input  logic                 trig,
    input  logic [2:0]           tap_mask,
    output logic [1:0]           res_axis,
    output logic                 res_pos,
    output logic                 res_done
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(POST + 1);

    tap_state_e             state, nxt;
    logic [CW-1:0]          post_cnt;
    logic [AW-1:0]          scan_idx;
    logic [NAX-1:0]         mask_lat;
    logic                   buf_we, freeze, scan_end, arm_trig;
    logic [NAX-1:0][DW-1:0] din, rd_data;
    logic [NAX-1:0][AW-1:0] first_pos;
    logic [NAX-1:0][DW:0]   swing;
    logic [NAX-1:0]         pos_dir;
    logic [1:0]             arb_axis;
    logic                   arb_dir;

    assign arm_trig = (state == ST_ARMED) && trig;
    assign buf_we   = smp_vld && (state == ST_ARMED || state == ST_POST);
    assign freeze   = (state == ST_POST) && smp_vld && post_cnt == CW'(POST - 1);
    assign scan_end = (state == ST_SCAN) && scan_idx == AW'(DEPTH - 1);
    assign din      = {smp_z, smp_y, smp_x};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_ARMED;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ARMED: if (arm_trig) nxt = ST_POST;   // ARM_TRIG
            ST_POST:  if (freeze)   nxt = ST_SCAN;   // POST_FULL
            ST_SCAN:  if (scan_end) nxt = ST_DONE;   // SCAN_END
            ST_DONE:                nxt = ST_ARMED;  // REARM
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_cnt <= '0;
            scan_idx <= '0;
            mask_lat <= '0;
        end else begin
            if (arm_trig) begin
                mask_lat <= tap_mask;
                post_cnt <= '0;
            end else if (state == ST_POST && smp_vld) begin
                post_cnt <= post_cnt + 1'b1;
            end
            if (freeze)                 scan_idx <= '0;
            else if (state == ST_SCAN)  scan_idx <= scan_idx + 1'b1;
        end
    end

    tap_capture_buf #(.DW(DW), .DEPTH(DEPTH), .NAX(NAX)) i_buf (
        .clk(clk), .rst_n(rst_n), .we(buf_we), .din(din),
        .rd_off(scan_idx), .dout(rd_data)
    );

    for (genvar g = 0; g < NAX; g++) begin : g_axis
        tap_peak_scan #(.DW(DW), .AW(AW)) i_scan (
            .clk(clk), .rst_n(rst_n), .clr(freeze),
            .en(state == ST_SCAN), .smp($signed(rd_data[g])), .pos(scan_idx),
            .first_pos(first_pos[g]), .swing(swing[g]), .pos_dir(pos_dir[g])
        );
    end

    tap_axis_arb #(.DW(DW), .AW(AW), .NAX(NAX)) i_arb (
        .mask(mask_lat), .first_pos(first_pos), .swing(swing),
        .pos_dir(pos_dir), .axis(arb_axis), .dir(arb_dir)
    );

    // output process
    always_comb begin
        res_done = 1'b0;
        res_axis = 2'd0;
        res_pos  = 1'b0;
        if (state == ST_DONE) begin
            res_done = 1'b1;
            res_axis = arb_axis;
            res_pos  = arb_dir;
        end
    end

    p_single_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> !res_done);
    p_done_from_scan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> $past(state) == ST_SCAN);
    p_post_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_POST |-> post_cnt < CW'(POST));
    p_no_axis_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && mask_lat == '0) |-> res_axis == 2'd0 && !res_pos);
    p_axis_flagged_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_done && res_axis != 2'd0) |-> mask_lat[res_axis - 2'd1]);
    p_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |-> res_axis == 2'd0 && !res_pos);
endmodule

// File: tb/test_tap_dir_classifier.sv
module test_tap_dir_classifier;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              vld = 1'b0, trig = 1'b0;
    logic signed [7:0] bx = '0, by = '0, bz = '0;
    logic [2:0]        mask = '0;
    logic [1:0]        res_axis;
    logic              res_pos, res_done;

    int checks = 0, fails = 0;
    int cx[32], cy[32], cz[32];

    // reference model state
    int hist[3][32];
    int m_st = 0, m_cnt = 0, m_busy = 0;
    logic [2:0] m_mask = '0;
    int e_axis = 0;
    bit e_pos = 0;

    always #10 clk = ~clk;

    tap_dir_classifier i_tap_dir_classifier (
        .clk(clk), .rst_n(rst_n), .smp_vld(vld), .smp_x(bx), .smp_y(by),
        .smp_z(bz), .trig(trig), .tap_mask(mask), .res_axis(res_axis),
        .res_pos(res_pos), .res_done(res_done)
    );

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic void model_push(int x, int y, int z);
        for (int a = 0; a < 3; a++)
            for (int i = 0; i < 31; i++) hist[a][i] = hist[a][i + 1];
        hist[0][31] = x; hist[1][31] = y; hist[2][31] = z;
    endfunction

    // R7 R8 R9 R10 R11 expected result from the frozen history
    function automatic void model_result();
        int bpos, bsw;
        bit found;
        found = 0; bpos = 0; bsw = 0; e_axis = 0; e_pos = 0;
        for (int a = 0; a < 3; a++) begin
            int mx, mn, pmx, pmn, fp, sw;
            bit dp;
            mx = hist[a][0]; mn = hist[a][0]; pmx = 0; pmn = 0;
            for (int i = 1; i < 32; i++) begin
                if (hist[a][i] > mx) begin mx = hist[a][i]; pmx = i; end
                if (hist[a][i] < mn) begin mn = hist[a][i]; pmn = i; end
            end
            fp = (pmx < pmn) ? pmx : pmn;
            sw = mx - mn;
            if (pmx < pmn)      dp = iabs(mx) > iabs(mn);
            else if (pmn < pmx) dp = iabs(mn) > iabs(mx);
            else                dp = 0;
            if (m_mask[a] && (!found || fp < bpos || (fp == bpos && sw > bsw))) begin
                found = 1; bpos = fp; bsw = sw; e_axis = a + 1; e_pos = dp;
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_busy = 0; m_mask = '0;
            for (int a = 0; a < 3; a++)
                for (int i = 0; i < 32; i++) hist[a][i] = 0;
        end else begin
            case (m_st)
                0: begin
                    if (vld) model_push(bx, by, bz);
                    if (trig) begin m_mask = mask; m_cnt = 0; m_st = 1; end
                end
                1: if (vld) begin
                    model_push(bx, by, bz);
                    m_cnt++;
                    if (m_cnt == 12) begin m_st = 2; m_busy = 32; model_result(); end
                end
                2: begin m_busy--; if (m_busy == 0) m_st = 3; end
                default: m_st = 0;
            endcase
        end
    end

    // per-cycle comparison against the model: R4 R12 R6 R9 R10
    always @(negedge clk) begin
        if (rst_n) begin
            bit ed;
            int ea;
            bit ep;
            ed = (m_st == 3);
            ea = ed ? e_axis : 0;
            ep = ed ? e_pos : 0;
            checks++;
            if (res_done !== ed || res_axis !== 2'(ea) || res_pos !== ep) begin
                fails++;
                $display("FAIL R4 R12 model: actual done=%0d axis=%0d pos=%0d expected done=%0d axis=%0d pos=%0d",
                         res_done, res_axis, res_pos, ed, ea, ep);
            end
        end
    end

    task automatic drive(input bit v, input int x, input int y, input int z,
                         input bit t, input logic [2:0] m);
        @(negedge clk);
        vld = v; bx = 8'(x); by = 8'(y); bz = 8'(z); trig = t; mask = m;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_case();
        for (int i = 0; i < 32; i++) begin cx[i] = 0; cy[i] = 0; cz[i] = 0; end
    endtask

    task automatic wait_result(input int ex_axis, input bit ex_pos, input string req);
        int lat;
        lat = 0;
        while (!res_done && lat < 100) begin
            // junk after the freeze must not be stored; stray triggers ignored (R3 R5)
            drive(1, -100, 100, -100, (lat % 5) == 1, 3'b111);
            lat++;
        end
        check(lat == 33, "R4 latency", lat, 33);
        check(res_axis == 2'(ex_axis), req, res_axis, ex_axis);
        check(res_pos == ex_pos, req, res_pos, ex_pos);
    endtask

    task automatic play(input logic [2:0] m, input int ex_axis, input bit ex_pos,
                        input string req);
        for (int j = 0; j < 5; j++) drive(1, 7, -7, 3, 0, m);
        for (int p = 0; p < 32; p++) begin
            if (p == 11 || p == 26) drive(0, 99, 99, 99, 0, m);  // R2 gap
            // trigger at p=19 (pre-trigger sample), stray trigger at p=24 (R5)
            drive(1, cx[p], cy[p], cz[p], (p == 19) || (p == 24), (p == 19) ? m : ~m);
        end
        wait_result(ex_axis, ex_pos, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(res_done == 0 && res_axis == 0 && res_pos == 0, "R1 reset outputs",
              {res_done, res_axis, res_pos}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(res_done == 0 && res_axis == 0, "R1 after reset", res_done, 0);

        clear_case(); cx[20] = 60; cx[22] = -30;
        play(3'b001, 1, 1, "R7 R8 single X positive");
        clear_case(); cy[21] = 20; cy[23] = -50;
        play(3'b010, 2, 0, "R8 Y negative");
        clear_case(); cx[22] = 50; cx[25] = -10; cy[20] = 30; cy[21] = -60;
        cz[24] = -90; cz[26] = 10;
        play(3'b111, 2, 0, "R9 earliest axis");
        clear_case(); cx[20] = 40; cx[21] = -40; cz[20] = -100; cz[22] = 20;
        play(3'b101, 3, 1, "R10 swing tie-break");
        clear_case(); cx[20] = 30; cx[21] = -30; cy[20] = 30; cy[21] = -30;
        play(3'b011, 1, 0, "R10 full tie lower code");
        clear_case(); cx[20] = 60; cx[22] = -30;
        play(3'b000, 0, 0, "R11 no axis");
        clear_case(); cx[20] = -50; cx[22] = 40; cx[24] = -50;
        play(3'b001, 1, 1, "R7 first occurrence");
        clear_case(); cz[20] = -128; cz[21] = 127;
        play(3'b100, 3, 1, "R8 full-scale magnitude");
        clear_case(); for (int i = 0; i < 32; i++) cx[i] = 5;
        play(3'b001, 1, 0, "R8 flat axis");

        // R13: trigger in the first cycle after done
        drive(1, 0, 0, 0, 1, 3'b000);
        for (int k = 0; k < 12; k++) drive(1, k, -k, k, 0, 3'b111);
        wait_result(0, 0, "R13 immediate re-trigger");

        drive(0, 0, 0, 0, 0, 3'b000);
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #4000000;
        fails++; checks++;
        $display("FAIL R4 watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule